// File: doc/BRIEF.md
# SHA-256 Nonce Search Engine

This block searches for a proof-of-work nonce. A controller supplies a 512-bit message block, a first nonce to try and a difficulty, and then pulses `start`. The engine writes the nonce into one word of the block. It runs one SHA-256 compression from the standard initial hash values, one round per clock. It then counts the leading zero bits of the resulting digest. If the count falls short of the difficulty, the engine moves to the next nonce and hashes again.

The search ends in one of two ways. A digest with enough leading zeros ends it with `found` and `done` both high, and the winning nonce and its digest stay on the outputs. If the nonce passes 0xFFFFFFFF without a hit, the search ends with `done` high and `found` low. In both cases the outputs hold until the next start. Each hash is a single compression of a single block, with no chaining and no second hash.

Top module: `nonce_search_engine`

## Requirements
- R1: A `start` pulse seen while the engine is not busy captures `block_in`, `nonce_start` and `difficulty`. `busy` is high in the next cycle, and `done` and `found` are cleared.
- R2: The hashed block is `block_in` with bits [415:384] (message word 3, where word 0 is bits [511:480]) replaced by the nonce. The compression starts from the standard SHA-256 initial values, and `digest_out` carries digest word 0 in bits [255:224].
- R3: Each hash takes 65 clock edges. When a search ends after k hashes, `done` is first seen high after the edge 65·k edges later than the edge that sampled `start`.
- R4: After each failed hash the nonce goes up by exactly one. While busy, `nonce_out` shows the nonce under test.
- R5: A hit is a digest whose leading zero count, taken from bit 255 down, is at least `difficulty`. The first hit raises `done` and `found`, with `nonce_out` and `digest_out` showing that nonce and its digest.
- R6: Once `done` is high, `done`, `found`, `nonce_out` and `digest_out` stay unchanged until the next `start`.
- R7: Suppose nonce 0xFFFFFFFF misses. The search then ends with `done` high and `found` low, `nonce_out` equal to 0xFFFFFFFF, and no wrap to zero.
- R8: A difficulty of 0 hits on the first hash. A difficulty of 256 hits only on an all-zero digest.
- R9: A `start` pulse while `busy` is high has no effect on the search in progress or on its result.
- R10: During and after reset, `busy`, `done` and `found` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search; ignored while busy |
| block_in | input | 512 | Message block, word 0 in the top bits |
| nonce_start | input | 32 | First nonce to try |
| difficulty | input | 9 | Required leading zero bits, 0 to 256 |
| busy | output | 1 | A search is running |
| done | output | 1 | The search has ended |
| found | output | 1 | The search ended on a hit |
| nonce_out | output | 32 | Nonce under test, or the final nonce when done |
| digest_out | output | 256 | Digest of the last finished hash |

## Verification
The bound checker watches these rules on every cycle:
- a launch from idle raises `busy`;
- `found` never appears without `done`, and `busy` and `done` are never high together;
- the nonce changes during a search only by a step of one;
- a finished result stays frozen until the next start;
- a start pulse in mid-search does not disturb it.

Other behaviours can only be shown by the bench's scenarios, checked against an independent SHA-256 model:
- the digest value for a known message;
- which nonce is the first hit;
- the exact end-of-search latency;
- the exhaustion case at 0xFFFFFFFF.

// File: rtl/nse_pkg.sv
package nse_pkg;

    localparam int WORD_W   = 32;
    localparam int BLOCK_W  = 512;
    localparam int DIGEST_W = 256;
    localparam int WIN      = 16;
    localparam int ROUNDS   = 64;
    localparam int RND_W    = $clog2(ROUNDS);
    localparam int STATE_N  = 8;
    localparam int DIFF_W   = $clog2(DIGEST_W + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HASH  = 2'd1,
        ST_CHECK = 2'd2,
        ST_DONE  = 2'd3
    } eng_st_e;

    typedef struct packed {
        eng_st_e               st;
        logic [RND_W-1:0]      round;
        word_t                 nonce;
        logic [DIFF_W-1:0]     diff;
        logic [BLOCK_W-1:0]    blk;
        logic                  done;
        logic                  found;
        logic [DIGEST_W-1:0]   digest;
    } eng_t;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t sm_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sm_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t bg_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t bg_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t f_ch(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t f_maj(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic word_t init_val(input int i);
        case (i)
            0: return 32'h6a09e667;
            1: return 32'hbb67ae85;
            2: return 32'h3c6ef372;
            3: return 32'ha54ff53a;
            4: return 32'h510e527f;
            5: return 32'h9b05688c;
            6: return 32'h1f83d9ab;
            default: return 32'h5be0cd19;
        endcase
    endfunction

    function automatic word_t round_k(input logic [RND_W-1:0] t);
        case (t)
            6'd0:  return 32'h428a2f98;  6'd1:  return 32'h71374491;
            6'd2:  return 32'hb5c0fbcf;  6'd3:  return 32'he9b5dba5;
            6'd4:  return 32'h3956c25b;  6'd5:  return 32'h59f111f1;
            6'd6:  return 32'h923f82a4;  6'd7:  return 32'hab1c5ed5;
            6'd8:  return 32'hd807aa98;  6'd9:  return 32'h12835b01;
            6'd10: return 32'h243185be;  6'd11: return 32'h550c7dc3;
            6'd12: return 32'h72be5d74;  6'd13: return 32'h80deb1fe;
            6'd14: return 32'h9bdc06a7;  6'd15: return 32'hc19bf174;
            6'd16: return 32'he49b69c1;  6'd17: return 32'hefbe4786;
            6'd18: return 32'h0fc19dc6;  6'd19: return 32'h240ca1cc;
            6'd20: return 32'h2de92c6f;  6'd21: return 32'h4a7484aa;
            6'd22: return 32'h5cb0a9dc;  6'd23: return 32'h76f988da;
            6'd24: return 32'h983e5152;  6'd25: return 32'ha831c66d;
            6'd26: return 32'hb00327c8;  6'd27: return 32'hbf597fc7;
            6'd28: return 32'hc6e00bf3;  6'd29: return 32'hd5a79147;
            6'd30: return 32'h06ca6351;  6'd31: return 32'h14292967;
            6'd32: return 32'h27b70a85;  6'd33: return 32'h2e1b2138;
            6'd34: return 32'h4d2c6dfc;  6'd35: return 32'h53380d13;
            6'd36: return 32'h650a7354;  6'd37: return 32'h766a0abb;
            6'd38: return 32'h81c2c92e;  6'd39: return 32'h92722c85;
            6'd40: return 32'ha2bfe8a1;  6'd41: return 32'ha81a664b;
            6'd42: return 32'hc24b8b70;  6'd43: return 32'hc76c51a3;
            6'd44: return 32'hd192e819;  6'd45: return 32'hd6990624;
            6'd46: return 32'hf40e3585;  6'd47: return 32'h106aa070;
            6'd48: return 32'h19a4c116;  6'd49: return 32'h1e376c08;
            6'd50: return 32'h2748774c;  6'd51: return 32'h34b0bcb5;
            6'd52: return 32'h391c0cb3;  6'd53: return 32'h4ed8aa4a;
            6'd54: return 32'h5b9cca4f;  6'd55: return 32'h682e6ff3;
            6'd56: return 32'h748f82ee;  6'd57: return 32'h78a5636f;
            6'd58: return 32'h84c87814;  6'd59: return 32'h8cc70208;
            6'd60: return 32'h90befffa;  6'd61: return 32'ha4506ceb;
            6'd62: return 32'hbef9a3f7;  default: return 32'hc67178f2;
        endcase
    endfunction

endpackage

// File: rtl/nse_msg_window.sv
module nse_msg_window
    import nse_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic [WIN-1:0][WORD_W-1:0] load_words,
    output word_t                 w_cur
);

    logic [WIN-1:0][WORD_W-1:0] win_d, win_q;
    word_t                      w_new;

    // With win_q[0] = W[t], the word entering the window is W[t+16]
    always_comb begin
        w_new = sm_sig1(win_q[14]) + win_q[9] + sm_sig0(win_q[1]) + win_q[0];
        win_d = win_q;
        if (load) begin
            win_d = load_words;
        end else if (step) begin
            for (int i = 0; i < WIN - 1; i++) begin
                win_d[i] = win_q[i+1];
            end
            win_d[WIN-1] = w_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign w_cur = win_q[0];

endmodule

// File: rtl/nse_round_core.sv
module nse_round_core
    import nse_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  word_t               k_t,
    input  word_t               w_t,
    output logic [DIGEST_W-1:0] digest
);

    // index 0 = a ... index 7 = h
    logic [STATE_N-1:0][WORD_W-1:0] v_d, v_q;
    word_t t1, t2;

    always_comb begin
        t1  = v_q[7] + bg_sig1(v_q[4]) + f_ch(v_q[4], v_q[5], v_q[6]) + k_t + w_t;
        t2  = bg_sig0(v_q[0]) + f_maj(v_q[0], v_q[1], v_q[2]);
        v_d = v_q;
        if (load) begin
            for (int i = 0; i < STATE_N; i++) v_d[i] = init_val(i);
        end else if (step) begin
            for (int i = 1; i < STATE_N; i++) v_d[i] = v_q[i-1];
            v_d[0] = t1 + t2;
            v_d[4] = v_q[3] + t1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    for (genvar g = 0; g < STATE_N; g++) begin : g_fold
        assign digest[DIGEST_W-1-WORD_W*g -: WORD_W] = init_val(g) + v_q[g];
    end

endmodule

// File: rtl/nse_lead_zeros.sv
module nse_lead_zeros #(
    parameter int W   = 256,
    parameter int CNT = $clog2(W + 1)
) (
    input  logic [W-1:0]   vec,
    output logic [CNT-1:0] count
);

    always_comb begin
        logic seen_one;
        seen_one = 1'b0;
        count    = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) seen_one = 1'b1;
            if (!seen_one) count = count + 1'b1;
        end
    end

endmodule

// File: rtl/nonce_search_engine.sv
module nonce_search_engine
    import nse_pkg::*;
#(
    parameter int NONCE_WORD = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [BLOCK_W-1:0]   block_in,
    input  logic [WORD_W-1:0]    nonce_start,
    input  logic [DIFF_W-1:0]    difficulty,
    output logic                 busy,
    output logic                 done,
    output logic                 found,
    output logic [WORD_W-1:0]    nonce_out,
    output logic [DIGEST_W-1:0]  digest_out
);

    eng_t q, d;

    logic                        load, step;
    logic [BLOCK_W-1:0]          src_blk;
    word_t                       src_nonce;
    logic [WIN-1:0][WORD_W-1:0]  load_words;
    word_t                       w_t, k_t;
    logic [DIGEST_W-1:0]         digest;
    logic [DIFF_W-1:0]           zeros;

    always_comb begin
        d         = q;
        load      = 1'b0;
        step      = 1'b0;
        src_blk   = q.blk;
        src_nonce = q.nonce + 1'b1;
        unique case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    src_blk   = block_in;
                    src_nonce = nonce_start;
                    d.blk     = block_in;
                    d.nonce   = nonce_start;
                    d.diff    = difficulty;
                    d.round   = '0;
                    d.done    = 1'b0;
                    d.found   = 1'b0;
                    d.st      = ST_HASH;
                    load      = 1'b1;
                end
            end
            ST_HASH: begin
                step    = 1'b1;
                d.round = q.round + 1'b1;
                if (q.round == RND_W'(ROUNDS - 1)) d.st = ST_CHECK;
            end
            ST_CHECK: begin
                d.digest = digest;
                if (zeros >= q.diff) begin
                    d.found = 1'b1;
                    d.done  = 1'b1;
                    d.st    = ST_DONE;
                end else if (&q.nonce) begin
                    d.done  = 1'b1;
                    d.st    = ST_DONE;
                end else begin
                    d.nonce = q.nonce + 1'b1;
                    d.round = '0;
                    d.st    = ST_HASH;
                    load    = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < WIN; g++) begin : g_words
        if (g == NONCE_WORD) begin : g_nonce
            assign load_words[g] = src_nonce;
        end else begin : g_msg
            assign load_words[g] = src_blk[BLOCK_W-1-WORD_W*g -: WORD_W];
        end
    end

    assign k_t = round_k(q.round);

    nse_msg_window u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .load_words (load_words),
        .w_cur      (w_t)
    );

    nse_round_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .k_t    (k_t),
        .w_t    (w_t),
        .digest (digest)
    );

    nse_lead_zeros #(.W(DIGEST_W), .CNT(DIFF_W)) u_lz (
        .vec   (digest),
        .count (zeros)
    );

    assign busy       = (q.st == ST_HASH) || (q.st == ST_CHECK);
    assign done       = q.done;
    assign found      = q.found;
    assign nonce_out  = q.nonce;
    assign digest_out = q.digest;

endmodule

// File: rtl/nse_checker.sv
module nse_checker
    import nse_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic                found,
    input logic [WORD_W-1:0]   nonce_out,
    input logic [DIGEST_W-1:0] digest_out
);

    p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done && !found));

    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (nonce_out != $past(nonce_out)))
            |-> (nonce_out == $past(nonce_out) + 32'd1));

    p_found_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> done);

    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(found) && $stable(nonce_out)
                              && $stable(digest_out)));

    p_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_midrun_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind nonce_search_engine nse_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .found      (found),
    .nonce_out  (nonce_out),
    .digest_out (digest_out)
);

// File: tb/nonce_search_engine_tb.sv
module nonce_search_engine_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [511:0] block_in = '0;
    logic [31:0]  nonce_start = '0;
    logic [8:0]   difficulty = '0;
    logic         busy, done, found;
    logic [31:0]  nonce_out;
    logic [255:0] digest_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    nonce_search_engine u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .block_in    (block_in),
        .nonce_start (nonce_start),
        .difficulty  (difficulty),
        .busy        (busy),
        .done        (done),
        .found       (found),
        .nonce_out   (nonce_out),
        .digest_out  (digest_out)
    );

    // ---------------- independent reference model ----------------
    localparam logic [31:0] KT [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1,
        32'h923f82a4, 32'hab1c5ed5, 32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174, 32'he49b69c1, 32'hefbe4786,
        32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147,
        32'h06ca6351, 32'h14292967, 32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85, 32'ha2bfe8a1, 32'ha81a664b,
        32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a,
        32'h5b9cca4f, 32'h682e6ff3, 32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};
    localparam logic [255:0] HIV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        logic [63:0] dbl;
        dbl = {x, x} >> n;
        return dbl[31:0];
    endfunction

    function automatic logic [255:0] m_hash(input logic [511:0] b);
        logic [31:0] w [64];
        logic [31:0] s [8];
        logic [31:0] x1, x2;
        logic [255:0] r;
        for (int t = 0; t < 16; t++) w[t] = b[511-32*t -: 32];
        for (int t = 16; t < 64; t++)
            w[t] = (rr(w[t-2],17) ^ rr(w[t-2],19) ^ (w[t-2] >> 10)) + w[t-7]
                 + (rr(w[t-15],7) ^ rr(w[t-15],18) ^ (w[t-15] >> 3)) + w[t-16];
        for (int i = 0; i < 8; i++) s[i] = HIV[255-32*i -: 32];
        for (int t = 0; t < 64; t++) begin
            x1 = s[7] + (rr(s[4],6) ^ rr(s[4],11) ^ rr(s[4],25))
               + ((s[4] & s[5]) ^ (~s[4] & s[6])) + KT[t] + w[t];
            x2 = (rr(s[0],2) ^ rr(s[0],13) ^ rr(s[0],22))
               + ((s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]));
            for (int i = 7; i > 0; i--) s[i] = s[i-1];
            s[4] = s[4] + x1;
            s[0] = x1 + x2;
        end
        for (int i = 0; i < 8; i++) r[255-32*i -: 32] = HIV[255-32*i -: 32] + s[i];
        return r;
    endfunction

    function automatic int m_zeros(input logic [255:0] v);
        int n = 0;
        while (n < 256 && !v[255-n]) n++;
        return n;
    endfunction

    task automatic m_search(input logic [511:0] b, input logic [31:0] ns, input int diff,
                            output bit hit, output logic [31:0] n_end,
                            output logic [255:0] dg, output int hashes);
        logic [511:0] bb;
        logic [31:0]  n;
        n = ns; hashes = 0; hit = 0;
        forever begin
            bb = b; bb[415:384] = n;
            dg = m_hash(bb);
            hashes++;
            if (m_zeros(dg) >= diff) begin hit = 1; break; end
            if (n == 32'hffffffff) break;
            n++;
        end
        n_end = n;
    endtask

    // ---------------- bench helpers ----------------
    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] mk_block(input logic [31:0] seed);
        logic [511:0] b;
        for (int i = 0; i < 16; i++) b[511-32*i -: 32] = seed ^ (32'h9e3779b9 * (i + 1));
        return b;
    endfunction

    // launch at negedge; returns edges counted from the start-sampling edge
    task automatic run(input logic [511:0] b, input logic [31:0] ns, input logic [8:0] df,
                       output int edges);
        @(negedge clk);
        block_in = b; nonce_start = ns; difficulty = df; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        while (!done && edges < 150000) begin
            @(negedge clk);
            edges++;
        end
        if (!done) check(1'b0, "watchdog", 256'(edges), 256'd0);
    endtask

    task automatic run_and_check(input logic [511:0] b, input logic [31:0] ns,
                                 input logic [8:0] df, input string tag);
        bit hit; logic [31:0] en; logic [255:0] ed; int hs, edges;
        m_search(b, ns, int'(df), hit, en, ed, hs);
        run(b, ns, df, edges);
        check(found == hit,  {tag, " R5 found"},  256'(found), 256'(hit));
        check(nonce_out == en, {tag, " R4 nonce"}, 256'(nonce_out), 256'(en));
        check(digest_out == ed, {tag, " R5 digest"}, digest_out, ed);
        check(edges == 65*hs + 1, {tag, " R3 latency"}, 256'(edges), 256'(65*hs + 1));
    endtask

    localparam logic [72:0] VEC [5] = '{
        {32'h1234abcd, 32'h00000000, 9'd4},
        {32'hdeadbeef, 32'h000003e8, 9'd6},
        {32'h0badf00d, 32'hfffffff0, 9'd2},
        {32'hcafe0001, 32'h0000004d, 9'd7},
        {32'h13572468, 32'h00000005, 9'd1}
    };

    localparam logic [511:0]  ABC_BLK = {32'h61626380, 448'h0, 32'h00000018};
    localparam logic [255:0]  ABC_DIG = {32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
                                         32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};

    initial begin
        #1500000;
        check(1'b0, "watchdog global", 256'd0, 256'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int edges;
        logic [31:0]  keep_n;
        logic [255:0] keep_d;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !found, "R10 reset outputs", {busy, done, found}, 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !found, "R10 after reset", {busy, done, found}, 256'd0);

        // R2 / R8: known message, difficulty 0 -> first hash, digest is known value
        check(m_hash(ABC_BLK) == ABC_DIG, "R2 model self", m_hash(ABC_BLK), ABC_DIG);
        run(ABC_BLK, 32'h0, 9'd0, edges);
        check(digest_out == ABC_DIG, "R2 digest known block", digest_out, ABC_DIG);
        check(found && done, "R8 diff0 hit", {found, done}, 256'd3);
        check(nonce_out == 32'h0, "R8 diff0 nonce", 256'(nonce_out), 256'd0);
        check(edges == 66, "R3 single hash latency", 256'(edges), 256'd66);

        // R1 / R5 / R3 / R4: vector table
        foreach (VEC[i]) begin
            run_and_check(mk_block(VEC[i][72:41]), VEC[i][40:9], VEC[i][8:0],
                          $sformatf("vec%0d", i));
        end

        // R6: result held with no start
        keep_n = nonce_out; keep_d = digest_out;
        repeat (40) @(negedge clk);
        check(done && nonce_out == keep_n && digest_out == keep_d, "R6 hold",
              256'(nonce_out), 256'(keep_n));

        // R7 / R8: difficulty 256 starting at the last nonce
        run(mk_block(32'h55aa55aa), 32'hffffffff, 9'd256, edges);
        check(done && !found, "R7 exhaust flags", {done, found}, 256'd2);
        check(nonce_out == 32'hffffffff, "R7 no wrap", 256'(nonce_out), 256'hffffffff);
        check(edges == 66, "R7 latency one hash", 256'(edges), 256'd66);
        run(mk_block(32'h55aa55aa), 32'hfffffffe, 9'd256, edges);
        check(edges == 131 && !found, "R7 two hashes", 256'(edges), 256'd131);

        // R9: start mid-search is ignored
        begin
            bit hit; logic [31:0] en; logic [255:0] ed; int hs;
            logic [511:0] b9;
            b9 = mk_block(32'h24681357);
            m_search(b9, 32'h10, 5, hit, en, ed, hs);
            @(negedge clk);
            block_in = b9; nonce_start = 32'h10; difficulty = 9'd5; start = 1'b1;
            @(negedge clk);
            start = 1'b0; edges = 1;
            repeat (20) begin @(negedge clk); edges++; end
            nonce_start = 32'h12345; difficulty = 9'd0; block_in = '0; start = 1'b1;
            @(negedge clk); edges++;
            start = 1'b0;
            while (!done && edges < 150000) begin @(negedge clk); edges++; end
            check(nonce_out == en && digest_out == ed, "R9 ignored start result",
                  256'(nonce_out), 256'(en));
            check(edges == 65*hs + 1, "R9 ignored start latency", 256'(edges),
                  256'(65*hs + 1));
        end

        // R1: restart from done clears flags next cycle
        @(negedge clk);
        block_in = ABC_BLK; nonce_start = 32'h0; difficulty = 9'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done && !found, "R1 restart clears", {busy, done, found}, 256'd4);

        repeat (70) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule